// File: doc/BRIEF.md
# Interrupt Distributor State Registers

This block is the per-interrupt state store of an interrupt distributor. It keeps five items for every interrupt: an enable bit, a pending latch, an active bit, a priority value and a trigger mode. Software reaches this state over a simple register bus. Each access is a single aligned 32-bit word and carries an address, write data, a write strobe and a read strobe. The block answers a read with a registered word one cycle later. A per-interrupt pulse input lets the interrupt sources set the pending latch directly.

The three one-bit states each have two windows. A write to the set window raises the bits that are 1 in the data. A write to the clear window lowers them. Reads from either window return the same state. Priority is held one byte per interrupt, and only its top `PRIO_BITS` bits are stored. The trigger mode is held as a 2-bit field per interrupt. The first `NUM_PRIV` interrupts are private and their trigger mode cannot be changed. `NUM_IRQ` must be a multiple of 32.

Byte address map (12-bit address):

| Window | Base |
|---|---|
| enable set / enable clear | 0x000 / 0x080 |
| pending set / pending clear | 0x100 / 0x180 |
| active set / active clear | 0x200 / 0x280 |
| priority | 0x400 |
| trigger mode | 0xC00 |

The read path is a two-state machine with these states:
- `RS_IDLE`: no read data is presented. It moves to `RS_DATA` when `rd_en` is high and stays in `RS_IDLE` otherwise.
- `RS_DATA`: `rd_valid` is high and `rdata` holds the captured word. It stays in `RS_DATA` on a back-to-back read and returns to `RS_IDLE` otherwise.

Top module: `irq_state_regs`

## Requirements
- R1: After reset, every enable, pending and active bit is 0, every priority reads 0, every interrupt reads as level-sensitive (field 2'b00), and `rd_valid` is 0.
- R2: In the one-bit windows, the word at byte offset 4*w covers interrupts 32*w to 32*w+31. Data bit b of that word maps to interrupt 32*w+b.
- R3: A write to a set window sets the state bit for every 1 in `wdata`. Bits whose data is 0 keep their value, and the state does not change unless such a write occurs.
- R4: A write to a clear window clears the state bit for every 1 in `wdata`. Bits whose data is 0 keep their value.
- R5: For the same word, a read through the set window and a read through the clear window return the same current state.
- R6: In the priority window, the word at byte offset 4*w holds interrupts 4*w to 4*w+3, with byte i (bits 8i+7..8i) belonging to interrupt 4*w+i.
- R7: A priority write keeps only the upper `PRIO_BITS` bits of each byte. The lower 8-`PRIO_BITS` bits always read 0, which is mask 0xF8 per byte at the default of 5.
- R8: In the trigger-mode window, the word at byte offset 4*w holds interrupts 16*w to 16*w+15 in 2-bit fields, field k at bits 2k+1..2k. A field reads 2'b10 for edge and 2'b00 for level. On a write, bit 2k+1 selects edge (1) or level (0), and bit 2k is ignored.
- R9: Trigger-mode writes to interrupts below `NUM_PRIV` are ignored, and those interrupts stay level-sensitive.
- R10: A high bit on `hw_pend_set` sets that interrupt's pending latch at the next edge. If a pending-clear write hits the same interrupt in the same cycle, the latch stays set.
- R11: `rd_valid` is high and `rdata` is valid in exactly the cycle after `rd_en`. A write takes effect at the next clock edge, so a read issued in the following cycle returns the new value.
- R12: A read of an unmapped address, a misaligned address or a word beyond `NUM_IRQ` returns 0. A write to any of these changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | `rdata` holds the answer to the previous cycle's read |
| hw_pend_set | input | NUM_IRQ | Per-interrupt pending-set pulses from the sources |

## Verification
The bench targets several corner cases that each show up as a wrong read value.

- Set and clear windows: if the two were swapped, or if zero data bits were written through instead of being skipped, the readback after a partial set or clear would show neighbouring bits that were wiped or wrongly raised.
- Priority truncation: a write of 0x12345678 must read back as 0x10305078. An untruncated bank, or one with its byte lanes reversed, returns a different word.
- Trigger mode: all-ones written to a shared word must read 0xAAAAAAAA. Writes to the private words must read 0. Writing the low bit of a field alone must change nothing.
- Clear against hardware set: a pending clear that lands in the same cycle as a hardware set pulse must leave that latch set, while still clearing a neighbouring bit in the same word.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [3:0] {
        WIN_NONE,
        WIN_EN_SET,
        WIN_EN_CLR,
        WIN_PD_SET,
        WIN_PD_CLR,
        WIN_AC_SET,
        WIN_AC_CLR,
        WIN_PRIO,
        WIN_CFG
    } win_e;

    typedef enum logic {
        RS_IDLE,
        RS_DATA
    } rd_state_e;

    // Map a byte address to its window; misaligned addresses map nowhere.
    function automatic win_e decode_win(input logic [ADDR_W-1:0] a);
        win_e w;
        w = WIN_NONE;
        if (a[1:0] == 2'b00) begin
            if (a[11:10] == 2'b00) begin
                case (a[9:7])
                    3'd0:    w = WIN_EN_SET;
                    3'd1:    w = WIN_EN_CLR;
                    3'd2:    w = WIN_PD_SET;
                    3'd3:    w = WIN_PD_CLR;
                    3'd4:    w = WIN_AC_SET;
                    3'd5:    w = WIN_AC_CLR;
                    default: w = WIN_NONE;
                endcase
            end else if (a[11:10] == 2'b01) begin
                w = WIN_PRIO;
            end else if (a[11:8] == 4'hC) begin
                w = WIN_CFG;
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/irq_bit_bank.sv
module irq_bit_bank #(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_mask,
    input  logic [NUM_IRQ-1:0] clr_mask,
    input  logic [NUM_IRQ-1:0] hw_set,
    output logic [NUM_IRQ-1:0] state_q
);

    // Set terms are applied after the clear term, so any set wins a collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= (state_q & ~clr_mask) | set_mask | hw_set;
        end
    end

endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
    parameter int NUM_IRQ   = 64,
    parameter int PRIO_BITS = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_IRQ/4-1:0]   word_we,
    input  logic [31:0]            wdata,
    output logic [NUM_IRQ*8-1:0]   prio_flat
);

    localparam int LOW_BITS = 8 - PRIO_BITS;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        logic [PRIO_BITS-1:0] prio_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q <= '0;
            end else if (word_we[i/4]) begin
                prio_q <= wdata[(i%4)*8+7 -: PRIO_BITS];
            end
        end

        assign prio_flat[i*8 +: 8] = 8'(prio_q) << LOW_BITS;
    end

endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank #(
    parameter int NUM_IRQ  = 64,
    parameter int NUM_PRIV = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IRQ/16-1:0] word_we,
    input  logic [31:0]           wdata,
    output logic [NUM_IRQ-1:0]    edge_q
);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        if (i < NUM_PRIV) begin : g_fixed
            assign edge_q[i] = 1'b0;
        end else begin : g_prog
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    edge_q[i] <= 1'b0;
                end else if (word_we[i/16]) begin
                    edge_q[i] <= wdata[(i%16)*2+1];
                end
            end
        end
    end

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
    import irq_regs_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int NUM_PRIV  = 32,
    parameter int PRIO_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    output logic              rd_valid,
    input  logic [NUM_IRQ-1:0] hw_pend_set
);

    localparam int NUM_BW = NUM_IRQ / 32;
    localparam int NUM_PW = NUM_IRQ / 4;
    localparam int NUM_CW = NUM_IRQ / 16;

    win_e       win;
    logic [4:0] bw_idx;
    logic [7:0] pw_idx;
    logic [5:0] cw_idx;

    assign win    = decode_win(addr);
    assign bw_idx = addr[6:2];
    assign pw_idx = addr[9:2];
    assign cw_idx = addr[7:2];

    logic [NUM_IRQ-1:0] en_set_m, en_clr_m, pd_set_m, pd_clr_m, ac_set_m, ac_clr_m;
    logic [NUM_IRQ-1:0] en_q, pd_q, ac_q, edge_q;
    logic [NUM_IRQ*8-1:0] prio_flat;
    logic [NUM_PW-1:0] pw_we;
    logic [NUM_CW-1:0] cw_we;

    // Write masks for the one-bit windows, one 32-bit lane per word.
    for (genvar w = 0; w < NUM_BW; w++) begin : g_bw
        logic hit;
        assign hit = wr_en && (int'(bw_idx) == w);
        assign en_set_m[w*32 +: 32] = (hit && win == WIN_EN_SET) ? wdata : '0;
        assign en_clr_m[w*32 +: 32] = (hit && win == WIN_EN_CLR) ? wdata : '0;
        assign pd_set_m[w*32 +: 32] = (hit && win == WIN_PD_SET) ? wdata : '0;
        assign pd_clr_m[w*32 +: 32] = (hit && win == WIN_PD_CLR) ? wdata : '0;
        assign ac_set_m[w*32 +: 32] = (hit && win == WIN_AC_SET) ? wdata : '0;
        assign ac_clr_m[w*32 +: 32] = (hit && win == WIN_AC_CLR) ? wdata : '0;
    end

    for (genvar w = 0; w < NUM_PW; w++) begin : g_pw
        assign pw_we[w] = wr_en && (win == WIN_PRIO) && (int'(pw_idx) == w);
    end

    for (genvar w = 0; w < NUM_CW; w++) begin : g_cw
        assign cw_we[w] = wr_en && (win == WIN_CFG) && (int'(cw_idx) == w);
    end

    irq_bit_bank #(.NUM_IRQ(NUM_IRQ)) u_enable (
        .clk(clk), .rst_n(rst_n), .set_mask(en_set_m), .clr_mask(en_clr_m),
        .hw_set('0), .state_q(en_q)
    );

    irq_bit_bank #(.NUM_IRQ(NUM_IRQ)) u_pending (
        .clk(clk), .rst_n(rst_n), .set_mask(pd_set_m), .clr_mask(pd_clr_m),
        .hw_set(hw_pend_set), .state_q(pd_q)
    );

    irq_bit_bank #(.NUM_IRQ(NUM_IRQ)) u_active (
        .clk(clk), .rst_n(rst_n), .set_mask(ac_set_m), .clr_mask(ac_clr_m),
        .hw_set('0), .state_q(ac_q)
    );

    irq_prio_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_prio (
        .clk(clk), .rst_n(rst_n), .word_we(pw_we), .wdata(wdata),
        .prio_flat(prio_flat)
    );

    irq_cfg_bank #(.NUM_IRQ(NUM_IRQ), .NUM_PRIV(NUM_PRIV)) u_cfg (
        .clk(clk), .rst_n(rst_n), .word_we(cw_we), .wdata(wdata),
        .edge_q(edge_q)
    );

    // Read word selection; anything unmatched reads zero.
    logic [31:0] rd_word;
    always_comb begin
        rd_word = '0;
        case (win)
            WIN_EN_SET, WIN_EN_CLR: begin
                for (int w = 0; w < NUM_BW; w++)
                    if (int'(bw_idx) == w) rd_word = en_q[w*32 +: 32];
            end
            WIN_PD_SET, WIN_PD_CLR: begin
                for (int w = 0; w < NUM_BW; w++)
                    if (int'(bw_idx) == w) rd_word = pd_q[w*32 +: 32];
            end
            WIN_AC_SET, WIN_AC_CLR: begin
                for (int w = 0; w < NUM_BW; w++)
                    if (int'(bw_idx) == w) rd_word = ac_q[w*32 +: 32];
            end
            WIN_PRIO: begin
                for (int w = 0; w < NUM_PW; w++)
                    if (int'(pw_idx) == w) rd_word = prio_flat[w*32 +: 32];
            end
            WIN_CFG: begin
                for (int w = 0; w < NUM_CW; w++)
                    if (int'(cw_idx) == w)
                        for (int k = 0; k < 16; k++)
                            rd_word[2*k+1] = edge_q[w*16+k];
            end
            default: rd_word = '0;
        endcase
    end

    // Read response state machine.
    rd_state_e st_q, st_d;
    logic [31:0] rdata_q;

    always_comb begin
        unique case (st_q)
            RS_IDLE: st_d = rd_en ? RS_DATA : RS_IDLE;
            RS_DATA: st_d = rd_en ? RS_DATA : RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= RS_IDLE;
            rdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (rd_en) rdata_q <= rd_word;
        end
    end

    always_comb begin
        rd_valid = (st_q == RS_DATA);
        rdata    = rdata_q;
    end

endmodule

// File: rtl/irq_state_regs_chk.sv
module irq_state_regs_chk
    import irq_regs_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int PRIO_BITS = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr,
    input logic               wr_en,
    input logic               rd_en,
    input logic [31:0]        rdata,
    input logic               rd_valid,
    input logic [NUM_IRQ-1:0] hw_pend_set,
    input logic [NUM_IRQ-1:0] en_q,
    input logic [NUM_IRQ-1:0] pd_q,
    input logic [NUM_IRQ-1:0] ac_q
);

    localparam logic [7:0]  LOW_BYTE = 8'((1 << (8 - PRIO_BITS)) - 1);
    localparam logic [31:0] LOW_MASK = {4{LOW_BYTE}};

    // R11: the response flag follows the read strobe by exactly one cycle
    p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R7: priority read data never carries unimplemented low bits
    p_prio_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && decode_win($past(addr)) == WIN_PRIO) |-> ((rdata & LOW_MASK) == '0));

    // R10: a source pulse leaves its pending latch set in the next cycle
    p_hw_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_pend_set != '0) |=> ((pd_q & $past(hw_pend_set)) == $past(hw_pend_set)));

    // R3: enable and active bits only move on a bus write
    p_en_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));
    p_ac_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ac_q));

    // R4: pending bits only move on a bus write or a source pulse
    p_pd_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hw_pend_set == '0) |=> $stable(pd_q));

endmodule

bind irq_state_regs irq_state_regs_chk #(
    .NUM_IRQ(NUM_IRQ),
    .PRIO_BITS(PRIO_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .rd_valid(rd_valid), .hw_pend_set(hw_pend_set),
    .en_q(en_q), .pd_q(pd_q), .ac_q(ac_q)
);

// File: tb/irq_state_regs_bench.sv
module irq_state_regs_bench;

    localparam int NUM_IRQ = 64;

    localparam logic [11:0] EN_SET = 12'h000, EN_CLR = 12'h080;
    localparam logic [11:0] PD_SET = 12'h100, PD_CLR = 12'h180;
    localparam logic [11:0] AC_SET = 12'h200, AC_CLR = 12'h280;
    localparam logic [11:0] PRIO   = 12'h400, CFG    = 12'hC00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [31:0] rdata;
    logic rd_valid;
    logic [NUM_IRQ-1:0] hw_pend_set = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_state_regs u_irq_state_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .rd_valid(rd_valid),
        .hw_pend_set(hw_pend_set)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R11 rd_valid after read", 32'(rd_valid), 32'd1);
        d = rdata;
    endtask

    task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset();
        check("R1 rd_valid low after reset", 32'(rd_valid), 32'd0);
        expect_rd("R1 enable word0", EN_SET, 32'h0);
        expect_rd("R1 pending word1", PD_CLR + 12'h4, 32'h0);
        expect_rd("R1 active word1", AC_SET + 12'h4, 32'h0);
        expect_rd("R1 priority word5", PRIO + 12'h14, 32'h0);
        expect_rd("R1 config word3", CFG + 12'hC, 32'h0);
    endtask

    task automatic t_enable();
        bus_wr(EN_SET + 12'h4, 32'h0000_8001);
        expect_rd("R2 enable word1 via set", EN_SET + 12'h4, 32'h0000_8001);
        expect_rd("R5 enable word1 via clear", EN_CLR + 12'h4, 32'h0000_8001);
        expect_rd("R2 enable word0 untouched", EN_SET, 32'h0);
        bus_wr(EN_SET + 12'h4, 32'h0000_0010);
        expect_rd("R3 zeros keep enable bits", EN_SET + 12'h4, 32'h0000_8011);
        bus_wr(EN_CLR + 12'h4, 32'h0000_8000);
        expect_rd("R4 clear enable bit", EN_CLR + 12'h4, 32'h0000_0011);
    endtask

    task automatic t_active();
        bus_wr(AC_SET, 32'hF0F0_0000);
        bus_wr(AC_CLR, 32'h3000_0000);
        expect_rd("R4 active partial clear", AC_CLR, 32'hC0F0_0000);
        expect_rd("R5 active via set window", AC_SET, 32'hC0F0_0000);
    endtask

    task automatic t_prio();
        bus_wr(PRIO + 12'h24, 32'h1234_5678);
        expect_rd("R7 priority truncation", PRIO + 12'h24, 32'h1030_5078);
        bus_wr(PRIO + 12'h28, 32'hFF00_0000);
        expect_rd("R6 top byte is interrupt base+3", PRIO + 12'h28, 32'hF800_0000);
        expect_rd("R6 neighbour word unchanged", PRIO + 12'h24, 32'h1030_5078);
    endtask

    task automatic t_cfg();
        bus_wr(CFG + 12'h8, 32'hFFFF_FFFF);
        expect_rd("R8 all shared edge", CFG + 12'h8, 32'hAAAA_AAAA);
        bus_wr(CFG + 12'h8, 32'h0000_0001);
        expect_rd("R8 low field bit ignored", CFG + 12'h8, 32'h0);
        bus_wr(CFG + 12'h8, 32'h0000_0008);
        expect_rd("R8 single edge field", CFG + 12'h8, 32'h0000_0008);
        bus_wr(CFG, 32'hFFFF_FFFF);
        bus_wr(CFG + 12'h4, 32'hFFFF_FFFF);
        expect_rd("R9 private word0 locked", CFG, 32'h0);
        expect_rd("R9 private word1 locked", CFG + 12'h4, 32'h0);
    endtask

    task automatic t_hw_pending();
        @(negedge clk);
        hw_pend_set = 64'h1 << 40;
        @(negedge clk);
        hw_pend_set = '0;
        expect_rd("R10 source pulse sets pending", PD_SET + 12'h4, 32'h0000_0100);
        bus_wr(PD_SET + 12'h4, 32'h0000_0200);
        expect_rd("R3 pending set", PD_CLR + 12'h4, 32'h0000_0300);
        @(negedge clk);
        addr = PD_CLR + 12'h4; wdata = 32'h0000_0300; wr_en = 1'b1;
        hw_pend_set = 64'h1 << 40;
        @(negedge clk);
        wr_en = 1'b0; hw_pend_set = '0;
        expect_rd("R10 source set beats clear", PD_SET + 12'h4, 32'h0000_0100);
        bus_wr(PD_CLR + 12'h4, 32'h0000_0100);
        expect_rd("R4 pending clear", PD_SET + 12'h4, 32'h0);
    endtask

    task automatic t_latency();
        logic [31:0] d;
        bus_wr(EN_SET, 32'h0000_0005);
        bus_rd(EN_SET, d);
        check("R11 read right after write", d, 32'h0000_0005);
        @(negedge clk);
        check("R11 rd_valid drops", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_unmapped();
        expect_rd("R12 unmapped read", 12'h300, 32'h0);
        bus_wr(12'h300, 32'hFFFF_FFFF);
        bus_wr(EN_SET + 12'h1, 32'hFFFF_FFFF);
        expect_rd("R12 stray writes leave enable", EN_SET, 32'h0000_0005);
        expect_rd("R12 misaligned read", EN_SET + 12'h1, 32'h0);
        bus_wr(EN_SET + 12'h8, 32'hFFFF_FFFF);
        expect_rd("R12 enable word beyond range", EN_SET + 12'h8, 32'h0);
        bus_wr(PRIO + 12'h40, 32'hFFFF_FFFF);
        expect_rd("R12 priority beyond range", PRIO + 12'h40, 32'h0);
        expect_rd("R12 config beyond range", CFG + 12'h10, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_active();
        t_prio();
        t_cfg();
        t_hw_pending();
        t_latency();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule